// File: doc/BRIEF.md
# Processor Status Exchange and Interrupt Sequencer

This block holds the processor status: channel mask, I/O enable, external enable, translation mode, protection key, flag nibble, condition code, program mask, instruction length code and program counter. When an interrupt is accepted it writes the current status to memory as a two-word image at a fixed old-status address. It then reads two words from that address plus 0x40 and loads them as the new status. The image layout is either basic or extended, selected by the `ec_mode` input.

Three interrupt sources compete for service. A channel request is taken only with I/O enable set. External and timer requests need the external enable and their own bit of an external subclass mask. The block also performs the set-mask operation from a byte, and accepts a simple update of program counter, length code, condition code and program mask from the execution side. It raises `halt` when the wait flag is set and both enables are clear.

Top module: `psw_xchg`

## Requirements
- R1: After reset all status fields are zero, `busy`, `spec_exc`, `halt` and all acknowledge outputs are low, and the external subclass mask is 0xFF.
- R2: In basic format (ec_mode=0) the first stored word is {channel mask[31:25], external enable[24], key[23:20], flags[19:16], interruption code[15:0]} and the second is {length code[31:30], condition code[29:28], program mask[27:24], program counter[23:0]}.
- R3: In extended format (ec_mode=1) the first stored word is {zero[31:28], translation mode[27:26], I/O enable[25], external enable[24], key[23:20], flags[19:16], length code[15:14], condition code[13:12], program mask[11:8], zero[7:0]} and the second is the program counter, zero-extended.
- R4: An accepted interrupt holds `busy` high for exactly four cycles. In those cycles the block writes the old address, writes old+4, reads old+0x40 and reads old+0x44. The old address is 0x038 for channel and 0x018 for external and timer. Read data is taken in the same cycle as `mem_rd`.
- R5: Priority is channel (needs I/O enable), then external (needs external enable and subclass bit 6), then timer (needs external enable and subclass bit 7). A request lacking its enables is not taken.
- R6: The stored interruption code is `chan_code` for a channel interrupt, 0x0040 for external and 0x0080 for timer. The stored length code is zero for every interrupt.
- R7: Loading in basic format sets channel mask from bits 31:25 of the first word, I/O enable to the OR of those bits, and condition code and program mask from second-word bits 29:28 and 27:24. Translation mode is kept.
- R8: Loading in extended format sets translation mode, I/O enable, condition code and program mask from first-word bits 27:26, 25, 13:12 and 11:8. The channel mask is kept. In both formats external enable, key, flags and program counter come from first-word bit 24, first-word bits 23:20 and 19:16, and second-word bits 23:0, and the length code becomes zero.
- R9: A loaded first word with bit 27 set pulses `spec_exc` for one cycle, in the first cycle the new status is visible.
- R10: Extended set-mask sets I/O enable from byte bit 1 and external enable from bit 0. A nonzero high nibble also pulses `spec_exc`.
- R11: Basic set-mask sets channel mask from byte bits 7:1, I/O enable to their OR, and external enable from bit 0.
- R12: `halt` is high exactly when flag bit 1 (the wait flag) is set and both I/O and external enables are clear.
- R13: Each accepted interrupt pulses exactly one of `ack_chan`, `ack_ext`, `ack_tmr`, in the first busy cycle.
- R14: `sub_we` loads the external subclass mask from `sub_wdata`. With subclass bit 7 clear, a timer request is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ec_mode | input | 1 | Selects the extended image format |
| chan_req | input | 1 | Channel interrupt pending |
| chan_code | input | 16 | Interruption code for a channel interrupt |
| ext_req | input | 1 | External signal pending |
| tmr_req | input | 1 | Interval timer pending |
| sub_we | input | 1 | Write external subclass mask |
| sub_wdata | input | 8 | New subclass mask |
| ssm_req | input | 1 | Perform set-mask |
| ssm_byte | input | 8 | Set-mask operand |
| upd_req | input | 1 | Update execution fields |
| upd_pc | input | 24 | New program counter |
| upd_ilc | input | 2 | New length code |
| upd_cc | input | 2 | New condition code |
| upd_pmsk | input | 4 | New program mask |
| mem_rdata | input | 32 | Memory read data, same cycle |
| mem_wr | output | 1 | Memory word write |
| mem_rd | output | 1 | Memory word read |
| mem_addr | output | 12 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| busy | output | 1 | Interrupt sequence running |
| ack_chan | output | 1 | Channel interrupt accepted |
| ack_ext | output | 1 | External interrupt accepted |
| ack_tmr | output | 1 | Timer interrupt accepted |
| spec_exc | output | 1 | Specification exception pulse |
| halt | output | 1 | Wait with all interrupts disabled |
| st_pc | output | 24 | Program counter |
| st_ilc | output | 2 | Length code |
| st_cc | output | 2 | Condition code |
| st_pmsk | output | 4 | Program mask |
| st_key | output | 4 | Protection key |
| st_flags | output | 4 | Flag nibble |
| st_chmask | output | 7 | Channel mask |
| st_ie | output | 1 | I/O enable |
| st_ee | output | 1 | External enable |
| st_xlat | output | 2 | Translation mode |

## Verification
The exchange is driven with a lone external request, with all three requests raised in one cycle, and with a timer request under a cleared and then a set subclass bit. These runs separate the priority order from the gating by enables. The same exchange runs in both formats with distinct nonzero field values, so a field in the wrong position or taken from the wrong word shows up as a mismatched word. Set-mask is tried with a legal and an illegal extended byte and with basic bytes that turn the mask on and off. A channel request is also raised after I/O enable is cleared, to show that it is ignored.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PC_W   = 24;
  localparam int CODE_W = 16;
  localparam int CHM_W  = 7;

  typedef struct packed {
    logic [1:0]       xlat;
    logic             ie;
    logic             ee;
    logic [CHM_W-1:0] chm;
    logic [3:0]       key;
    logic [3:0]       flg;
    logic [1:0]       ilc;
    logic [1:0]       cc;
    logic [3:0]       pm;
    logic [PC_W-1:0]  pc;
  } psw_t;

  typedef enum logic [2:0] {SQ_IDLE, SQ_WR0, SQ_WR1, SQ_RD0, SQ_RD1} seq_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_CHAN, SRC_EXT, SRC_TMR} src_e;

  // first word of a stored image
  function automatic logic [31:0] img_word0(psw_t s, logic ext, logic [CODE_W-1:0] code);
    if (ext) img_word0 = {4'b0, s.xlat, s.ie, s.ee, s.key, s.flg, s.ilc, s.cc, s.pm, 8'h00};
    else     img_word0 = {s.chm, s.ee, s.key, s.flg, code};
  endfunction

  // second word of a stored image
  function automatic logic [31:0] img_word1(psw_t s, logic ext);
    if (ext) img_word1 = {{(32-PC_W){1'b0}}, s.pc};
    else     img_word1 = {s.ilc, s.cc, s.pm, s.pc};
  endfunction

  // new status from a fetched two-word image
  function automatic psw_t img_load(psw_t cur, logic [31:0] w0, logic [31:0] w1, logic ext);
    psw_t n;
    n = cur;
    if (ext) begin
      n.xlat = w0[27:26];
      n.ie   = w0[25];
      n.cc   = w0[13:12];
      n.pm   = w0[11:8];
    end else begin
      n.chm  = w0[31:25];
      n.ie   = |w0[31:25];
      n.cc   = w1[29:28];
      n.pm   = w1[27:24];
    end
    n.ee  = w0[24];
    n.key = w0[23:20];
    n.flg = w0[19:16];
    n.ilc = 2'b00;
    n.pc  = w1[PC_W-1:0];
    return n;
  endfunction

  // set-mask operation
  function automatic psw_t mask_apply(psw_t cur, logic [7:0] b, logic ext);
    psw_t n;
    n = cur;
    n.ee = b[0];
    if (ext) n.ie = b[1];
    else begin
      n.chm = b[7:1];
      n.ie  = |b[7:1];
    end
    return n;
  endfunction

  function automatic logic mask_illegal(logic [7:0] b, logic ext);
    return ext && (b[7:4] != 4'h0);
  endfunction
endpackage

// File: rtl/psw_irq_arb.sv
module psw_irq_arb
  import psw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_req,
  input  logic       ext_req,
  input  logic       tmr_req,
  input  logic       ie,
  input  logic       ee,
  input  logic [7:0] sub_mask,
  output src_e       pick
);
  localparam int EXT_BIT = 6;
  localparam int TMR_BIT = 7;

  logic g_chan, g_ext, g_tmr;

  assign g_chan = chan_req && ie;
  assign g_ext  = ext_req && ee && sub_mask[EXT_BIT];
  assign g_tmr  = tmr_req && ee && sub_mask[TMR_BIT];

  always_comb begin
    if (g_chan)     pick = SRC_CHAN;
    else if (g_ext) pick = SRC_EXT;
    else if (g_tmr) pick = SRC_TMR;
    else            pick = SRC_NONE;
  end

  a_r5_chan_first: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_req && ie) |-> (pick == SRC_CHAN));
  a_r5_no_ext_without_ee: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee && !(chan_req && ie)) |-> (pick == SRC_NONE));
endmodule

// File: rtl/psw_state.sv
module psw_state
  import psw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_en,
  input  logic            ld_en,
  input  logic [31:0]     ld_w0,
  input  logic [31:0]     ld_w1,
  input  logic            ld_ext,
  input  logic            ssm_en,
  input  logic [7:0]      ssm_byte,
  input  logic            ssm_ext,
  input  logic            upd_en,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [1:0]      upd_ilc,
  input  logic [1:0]      upd_cc,
  input  logic [3:0]      upd_pmsk,
  output psw_t            st,
  output logic            spec_exc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= '0;
      spec_exc <= 1'b0;
    end else begin
      spec_exc <= 1'b0;
      if (ld_en) begin
        st       <= img_load(st, ld_w0, ld_w1, ld_ext);
        spec_exc <= ld_w0[27];
      end else if (take_en) begin
        st.ilc <= 2'b00;
      end else if (ssm_en) begin
        st       <= mask_apply(st, ssm_byte, ssm_ext);
        spec_exc <= mask_illegal(ssm_byte, ssm_ext);
      end else if (upd_en) begin
        st.pc  <= upd_pc;
        st.ilc <= upd_ilc;
        st.cc  <= upd_cc;
        st.pm  <= upd_pmsk;
      end
    end
  end

  a_r11_basic_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (ssm_en && !ssm_ext && !ld_en && !take_en) |=> (st.ie == |$past(ssm_byte[7:1])));
  a_r10_ext_ee: assert property (@(posedge clk) disable iff (!rst_n)
    (ssm_en && ssm_ext && !ld_en && !take_en) |=> (st.ee == $past(ssm_byte[0])));
  a_r8_ilc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (st.ilc == 2'b00));
endmodule

// File: rtl/psw_seq.sv
module psw_seq
  import psw_pkg::*;
#(
  parameter int          AW       = 12,
  parameter logic [AW-1:0] OLD_CHAN = 12'h038,
  parameter logic [AW-1:0] OLD_EXT  = 12'h018,
  parameter logic [AW-1:0] NEW_OFS  = 12'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  src_e              src,
  input  logic              ec_mode,
  input  logic [CODE_W-1:0] chan_code,
  input  psw_t              st,
  input  logic [31:0]       mem_rdata,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              busy,
  output logic              ack_chan,
  output logic              ack_ext,
  output logic              ack_tmr,
  output logic              ld_en,
  output logic [31:0]       ld_w0,
  output logic [31:0]       ld_w1,
  output logic              ld_ext
);
  localparam logic [AW-1:0] WSTEP = AW'(4);
  localparam logic [CODE_W-1:0] CODE_EXT = CODE_W'(16'h0040);
  localparam logic [CODE_W-1:0] CODE_TMR = CODE_W'(16'h0080);

  seq_e              state;
  src_e              src_q;
  logic              mode_q;
  logic [CODE_W-1:0] code_q;
  logic [31:0]       buf0;
  logic [AW-1:0]     base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      src_q  <= SRC_NONE;
      mode_q <= 1'b0;
      code_q <= '0;
      buf0   <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          state  <= SQ_WR0;
          src_q  <= src;
          mode_q <= ec_mode;
          code_q <= (src == SRC_CHAN) ? chan_code : (src == SRC_EXT) ? CODE_EXT : CODE_TMR;
        end
        SQ_WR0:  state <= SQ_WR1;
        SQ_WR1:  state <= SQ_RD0;
        SQ_RD0: begin
          buf0  <= mem_rdata;
          state <= SQ_RD1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign base = (src_q == SRC_CHAN) ? OLD_CHAN : OLD_EXT;

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      SQ_WR0: begin
        mem_addr  = base;
        mem_wdata = img_word0(st, mode_q, code_q);
      end
      SQ_WR1: begin
        mem_addr  = base + WSTEP;
        mem_wdata = img_word1(st, mode_q);
      end
      SQ_RD0:  mem_addr = base + NEW_OFS;
      SQ_RD1:  mem_addr = base + NEW_OFS + WSTEP;
      default: ;
    endcase
  end

  assign mem_wr   = (state == SQ_WR0) || (state == SQ_WR1);
  assign mem_rd   = (state == SQ_RD0) || (state == SQ_RD1);
  assign busy     = (state != SQ_IDLE);
  assign ack_chan = (state == SQ_WR0) && (src_q == SRC_CHAN);
  assign ack_ext  = (state == SQ_WR0) && (src_q == SRC_EXT);
  assign ack_tmr  = (state == SQ_WR0) && (src_q == SRC_TMR);
  assign ld_en    = (state == SQ_RD1);
  assign ld_w0    = buf0;
  assign ld_w1    = mem_rdata;
  assign ld_ext   = mode_q;

  a_r4_four_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> !busy);
  a_r4_write_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WR0) |=> (mem_wr && mem_addr == $past(mem_addr) + WSTEP));
  a_r4_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WR1) |=> mem_rd);
  a_r13_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_chan, ack_ext, ack_tmr}));
  a_r13_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_chan || ack_ext || ack_tmr) |=> !(ack_chan || ack_ext || ack_tmr));
endmodule

// File: rtl/psw_xchg.sv
module psw_xchg
  import psw_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ec_mode,
  input  logic              chan_req,
  input  logic [CODE_W-1:0] chan_code,
  input  logic              ext_req,
  input  logic              tmr_req,
  input  logic              sub_we,
  input  logic [7:0]        sub_wdata,
  input  logic              ssm_req,
  input  logic [7:0]        ssm_byte,
  input  logic              upd_req,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [1:0]        upd_ilc,
  input  logic [1:0]        upd_cc,
  input  logic [3:0]        upd_pmsk,
  input  logic [31:0]       mem_rdata,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              busy,
  output logic              ack_chan,
  output logic              ack_ext,
  output logic              ack_tmr,
  output logic              spec_exc,
  output logic              halt,
  output logic [PC_W-1:0]   st_pc,
  output logic [1:0]        st_ilc,
  output logic [1:0]        st_cc,
  output logic [3:0]        st_pmsk,
  output logic [3:0]        st_key,
  output logic [3:0]        st_flags,
  output logic [CHM_W-1:0]  st_chmask,
  output logic              st_ie,
  output logic              st_ee,
  output logic [1:0]        st_xlat
);
  localparam int WAIT_BIT = 1;

  psw_t        st;
  src_e        pick;
  logic [7:0]  sub_mask;
  logic        start, ssm_en, upd_en;
  logic        ld_en, ld_ext;
  logic [31:0] ld_w0, ld_w1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sub_mask <= 8'hFF;
    else if (sub_we) sub_mask <= sub_wdata;
  end

  assign start  = !busy && (pick != SRC_NONE);
  assign ssm_en = !busy && !start && ssm_req;
  assign upd_en = !busy && !start && !ssm_req && upd_req;

  psw_irq_arb u_arb (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .ext_req(ext_req), .tmr_req(tmr_req),
    .ie(st.ie), .ee(st.ee), .sub_mask(sub_mask), .pick(pick)
  );

  psw_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .src(pick), .ec_mode(ec_mode),
    .chan_code(chan_code), .st(st), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .ack_chan(ack_chan), .ack_ext(ack_ext), .ack_tmr(ack_tmr),
    .ld_en(ld_en), .ld_w0(ld_w0), .ld_w1(ld_w1), .ld_ext(ld_ext)
  );

  psw_state u_state (
    .clk(clk), .rst_n(rst_n), .take_en(start), .ld_en(ld_en), .ld_w0(ld_w0),
    .ld_w1(ld_w1), .ld_ext(ld_ext), .ssm_en(ssm_en), .ssm_byte(ssm_byte),
    .ssm_ext(ec_mode), .upd_en(upd_en), .upd_pc(upd_pc), .upd_ilc(upd_ilc),
    .upd_cc(upd_cc), .upd_pmsk(upd_pmsk), .st(st), .spec_exc(spec_exc)
  );

  assign halt      = st.flg[WAIT_BIT] && !st.ie && !st.ee;
  assign st_pc     = st.pc;
  assign st_ilc    = st.ilc;
  assign st_cc     = st.cc;
  assign st_pmsk   = st.pm;
  assign st_key    = st.key;
  assign st_flags  = st.flg;
  assign st_chmask = st.chm;
  assign st_ie     = st.ie;
  assign st_ee     = st.ee;
  assign st_xlat   = st.xlat;

  a_r12_halt_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!st_ie && !st_ee));
  a_r4_no_ops_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ld_en) |=> $stable(st));
  a_r6_ilc_cleared_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st_ilc == 2'b00));
endmodule

// File: tb/psw_xchg_tb_top.sv
module psw_xchg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ec_mode = 0, chan_req = 0, ext_req = 0, tmr_req = 0;
  logic [15:0] chan_code = 16'h0000;
  logic        sub_we = 0, ssm_req = 0, upd_req = 0;
  logic [7:0]  sub_wdata = 8'h00, ssm_byte = 8'h00;
  logic [23:0] upd_pc = '0;
  logic [1:0]  upd_ilc = '0, upd_cc = '0;
  logic [3:0]  upd_pmsk = '0;
  logic [31:0] mem_rdata;
  logic        mem_wr, mem_rd, busy, ack_chan, ack_ext, ack_tmr, spec_exc, halt;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [23:0] st_pc;
  logic [1:0]  st_ilc, st_cc, st_xlat;
  logic [3:0]  st_pmsk, st_key, st_flags;
  logic [6:0]  st_chmask;
  logic        st_ie, st_ee;

  always #10 clk = ~clk;

  logic [31:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[11:2]];

  psw_xchg dut_i (.*);

  integer errors = 0, checks = 0, cyc = 0;
  string  cur_tag = "R1";

  // reference model state
  integer m_ie, m_ee, m_xlat, m_chm, m_key, m_flg, m_ilc, m_cc, m_pm, m_pc;
  integer m_sub, m_phase, m_src, m_code, m_mode, m_spec, m_b0;
  string  m_spec_tag = "R9";

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic longint pack_state();
    return (longint'(m_ie) << 50) | (longint'(m_ee) << 49) | (longint'(m_xlat) << 47) |
           (longint'(m_chm) << 40) | (longint'(m_key) << 36) | (longint'(m_flg) << 32) |
           (longint'(m_ilc) << 30) | (longint'(m_cc) << 28) | (longint'(m_pm) << 24) |
           longint'(m_pc);
  endfunction

  function automatic integer old_addr();
    return (m_src == 1) ? 'h38 : 'h18;
  endfunction

  // model step at each rising edge
  always @(posedge clk) begin
    integer w0, w1;
    cyc++;
    if (!rst_n) begin
      m_ie = 0; m_ee = 0; m_xlat = 0; m_chm = 0; m_key = 0; m_flg = 0;
      m_ilc = 0; m_cc = 0; m_pm = 0; m_pc = 0; m_sub = 'hFF; m_phase = 0;
      m_src = 0; m_code = 0; m_mode = 0; m_spec = 0; m_b0 = 0;
    end else begin
      if (mem_wr) mem[mem_addr[11:2]] = mem_wdata;
      m_spec = 0;
      if (m_phase == 0) begin
        m_src = 0;
        if (chan_req && m_ie != 0) m_src = 1;
        else if (ext_req && m_ee != 0 && m_sub[6]) m_src = 2;
        else if (tmr_req && m_ee != 0 && m_sub[7]) m_src = 3;
        if (m_src != 0) begin
          m_phase = 1; m_mode = ec_mode; m_ilc = 0;
          m_code = (m_src == 1) ? chan_code : (m_src == 2) ? 'h40 : 'h80;
        end else if (ssm_req) begin
          m_ee = ssm_byte[0];
          if (ec_mode) begin
            m_ie = ssm_byte[1];
            m_spec = (ssm_byte >= 8'h10);
          end else begin
            m_chm = ssm_byte >> 1;
            m_ie = (m_chm != 0);
          end
          m_spec_tag = "R10";
        end else if (upd_req) begin
          m_pc = upd_pc; m_ilc = upd_ilc; m_cc = upd_cc; m_pm = upd_pmsk;
        end
      end else if (m_phase == 3) begin
        m_b0 = mem[(old_addr() + 'h40) / 4];
        m_phase = 4;
      end else if (m_phase == 4) begin
        w0 = m_b0;
        w1 = mem[(old_addr() + 'h44) / 4];
        if (m_mode != 0) begin
          m_xlat = (w0 >> 26) & 3; m_ie = (w0 >> 25) & 1;
          m_cc = (w0 >> 12) & 3;   m_pm = (w0 >> 8) & 15;
        end else begin
          m_chm = (w0 >> 25) & 'h7F; m_ie = (m_chm != 0);
          m_cc = (w1 >> 28) & 3;     m_pm = (w1 >> 24) & 15;
        end
        m_ee = (w0 >> 24) & 1; m_key = (w0 >> 20) & 15; m_flg = (w0 >> 16) & 15;
        m_ilc = 0; m_pc = w1 & 'hFFFFFF;
        m_spec = ((w0 >> 27) & 1);
        m_spec_tag = "R9";
        m_phase = 0;
      end else m_phase = m_phase + 1;
      if (sub_we) m_sub = sub_wdata;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    integer ea, ew;
    bit ewr, erd;
    if (rst_n) begin
      ewr = (m_phase == 1 || m_phase == 2);
      erd = (m_phase == 3 || m_phase == 4);
      chk(busy == (m_phase != 0), "R4 busy", busy, m_phase != 0);
      chk(mem_wr == ewr, "R4 mem_wr", mem_wr, ewr);
      chk(mem_rd == erd, "R4 mem_rd", mem_rd, erd);
      if (m_phase != 0) begin
        ea = old_addr() + ((m_phase == 2) ? 4 : (m_phase == 3) ? 'h40 : (m_phase == 4) ? 'h44 : 0);
        chk(mem_addr == ea, "R4 mem_addr", mem_addr, ea);
      end
      if (m_phase == 1) begin
        if (m_mode != 0)
          ew = (m_xlat << 26) + (m_ie << 25) + (m_ee << 24) + (m_key << 20) + (m_flg << 16) +
               (m_ilc << 14) + (m_cc << 12) + (m_pm << 8);
        else begin
          ew = (m_chm << 25) + (m_ee << 24) + (m_key << 20) + (m_flg << 16) + m_code;
          chk(mem_wdata[15:0] == m_code[15:0], "R6 code", mem_wdata[15:0], m_code);
        end
        chk(mem_wdata == ew, m_mode ? "R3 word0" : "R2 word0", mem_wdata, ew);
      end
      if (m_phase == 2) begin
        ew = m_mode ? m_pc : ((m_ilc << 30) | (m_cc << 28) | (m_pm << 24) | m_pc);
        chk(mem_wdata == ew, m_mode ? "R3 word1" : "R2 word1", mem_wdata, ew);
      end
      chk(ack_chan == (m_phase == 1 && m_src == 1), "R13 ack_chan", ack_chan, m_phase == 1 && m_src == 1);
      chk(ack_ext  == (m_phase == 1 && m_src == 2), "R13 ack_ext",  ack_ext,  m_phase == 1 && m_src == 2);
      chk(ack_tmr  == (m_phase == 1 && m_src == 3), "R13 ack_tmr",  ack_tmr,  m_phase == 1 && m_src == 3);
      chk(spec_exc == m_spec, m_spec_tag, spec_exc, m_spec);
      chk(halt == (m_flg[1] && m_ie == 0 && m_ee == 0), "R12 halt", halt,
          m_flg[1] && m_ie == 0 && m_ee == 0);
      chk({st_ie, st_ee, st_xlat, st_chmask, st_key, st_flags, st_ilc, st_cc, st_pmsk, st_pc}
          == pack_state(), cur_tag,
          {st_ie, st_ee, st_xlat, st_chmask, st_key, st_flags, st_ilc, st_cc, st_pmsk, st_pc},
          pack_state());
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_ssm(input logic [7:0] b);
    ssm_byte = b; ssm_req = 1; step(1); ssm_req = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 5000) begin
    errors++;
    $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cyc);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    mem['h58/4] = 32'hFF35_0000;  mem['h5C/4] = 32'h2A00_1000;  // external/timer vector
    mem['h78/4] = 32'h8131_0000;  mem['h7C/4] = 32'h1000_0200;  // channel vector
    step(3);
    rst_n = 1;
    step(3);                                // R1 reset state compared every cycle
    // basic mode
    cur_tag = "R11"; do_ssm(8'hA7); step(1);
    cur_tag = "R2";
    upd_pc = 24'h123456; upd_ilc = 2; upd_cc = 1; upd_pmsk = 5; upd_req = 1; step(1); upd_req = 0;
    cur_tag = "R7"; ext_req = 1; step(1); ext_req = 0; step(6);
    cur_tag = "R5"; chan_code = 16'h0123;
    chan_req = 1; ext_req = 1; tmr_req = 1; step(1);
    chan_req = 0; ext_req = 0; tmr_req = 0; step(6);
    cur_tag = "R14"; sub_wdata = 8'h7F; sub_we = 1; step(1); sub_we = 0;
    tmr_req = 1; step(3); tmr_req = 0; step(2);
    sub_wdata = 8'hFF; sub_we = 1; step(1); sub_we = 0;
    cur_tag = "R6"; tmr_req = 1; step(1); tmr_req = 0; step(6);
    cur_tag = "R11"; do_ssm(8'h00); step(1);
    cur_tag = "R5"; chan_req = 1; step(3); chan_req = 0; step(1);
    // extended mode
    ec_mode = 1;
    cur_tag = "R10"; do_ssm(8'h03); step(1); do_ssm(8'h13); step(1);
    mem['h58/4] = 32'h0B72_2600; mem['h5C/4] = 32'h00AB_CDEF;
    cur_tag = "R8";
    upd_pc = 24'h00_0777; upd_ilc = 1; upd_cc = 3; upd_pmsk = 9; upd_req = 1; step(1); upd_req = 0;
    ext_req = 1; step(1); ext_req = 0; step(6);
    cur_tag = "R12"; do_ssm(8'h00); step(2); do_ssm(8'h01); step(2);
    finish_run();
  end
endmodule